// File: doc/BRIEF.md
# Trace Log Ring Buffer

The block records one wide trace word on every clock into an on-chip ring memory. A write pointer, counted in whole entries, names the slot that receives the next word; it advances each cycle and wraps at the end of the memory, so the buffer always holds the most recent history. Recording stops while a freeze flag is held, which keeps the contents stable for readout.

Readback goes through two independent register sets, one used by the processor and one by a debug port. Each set has a pointer register and a data register. The pointer register shows the entry-granular write pointer in its upper half, with the buffer length ORed in so that software can find the size from the highest set bit. Its lower half holds the set's own freeze flag and read pointer, and the read pointer counts 64-bit doublewords. A read of the data register returns the doubleword at that set's read pointer and then advances the pointer. Each read answers on the following cycle with a response strobe.

Top module: `trace_ring_log`

## Requirements
- R1: In each cycle where neither freeze flag is set, `trace_in` is stored in the entry at the write pointer, and the write pointer then increments, wrapping from DEPTH-1 to 0.
- R2: A pointer-register read (cmd_valid=1, cmd_data_sel=0, cmd_write=0) is answered in the next cycle. Bits [63:32] hold (write pointer OR DEPTH), bit 31 holds that set's freeze flag, bits [RPW-1:0] hold its read pointer, and all other bits are zero. All values are those present in the cycle of the request.
- R3: A data-register read (cmd_data_sel=1, cmd_write=0) returns in the next cycle doubleword k of entry rp>>2, where k = rp[1:0] and doubleword k is trace bits [64k+63:64k].
- R4: Each data-register read increments that set's read pointer by one, wrapping from 4*DEPTH-1 to 0.
- R5: A pointer-register write (cmd_write=1, cmd_data_sel=0) loads the read pointer from wdata[RPW-1:0] and the freeze flag from wdata[31]. The other data bits are ignored, and the write pointer cannot be written.
- R6: While the freeze flag of either set is 1, nothing is written and the write pointer holds. Recording resumes in the cycle after both flags are clear.
- R7: Each set's read pointer and freeze flag change only through that set's own commands.
- R8: A write to the data register changes no state and produces no response.
- R9: After reset the write pointer, both read pointers and both freeze flags are zero. A response strobe is raised exactly in the cycle after a read command.
- R10: A data read of the entry being written in the same cycle returns that entry's previous contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| trace_in | input | TRACE_W | Trace word captured each unfrozen cycle |
| cpu_cmd_valid | input | 1 | Processor-side command strobe |
| cpu_cmd_data_sel | input | 1 | 0 = pointer register, 1 = data register |
| cpu_cmd_write | input | 1 | 1 = write, 0 = read |
| cpu_cmd_wdata | input | 64 | Processor-side write data |
| cpu_rsp_valid | output | 1 | Processor-side read response strobe |
| cpu_rsp_data | output | 64 | Processor-side read data |
| dbg_cmd_valid | input | 1 | Debug-side command strobe |
| dbg_cmd_data_sel | input | 1 | 0 = pointer register, 1 = data register |
| dbg_cmd_write | input | 1 | 1 = write, 0 = read |
| dbg_cmd_wdata | input | 64 | Debug-side write data |
| dbg_rsp_valid | output | 1 | Debug-side read response strobe |
| dbg_rsp_data | output | 64 | Debug-side read data |

## Verification
The bench first runs the buffer free for longer than its depth, which shows the write-pointer wrap in the pointer readback. Runs of back-to-back data reads then cross entry boundaries and the read-pointer wrap, and they show whether the doubleword select and the entry index are taken from the right pointer bits. Freeze is set from one set and cleared from the other, which tells an OR of the two flags apart from a flag that follows only the last writer. A read aimed at the slot being written in the same cycle separates read-before-write behaviour from write-first behaviour.

// File: rtl/trl_pkg.sv
package trl_pkg;
   // register select encoding on cmd_data_sel
   typedef enum logic {
      TRL_SEL_PTR  = 1'b0,
      TRL_SEL_DATA = 1'b1
   } trl_sel_e;

   localparam int TRL_REG_W      = 64;
   localparam int TRL_FREEZE_BIT = 31;
   localparam int TRL_HALF_W     = 32;
endpackage

// File: rtl/trl_ram.sv
module trl_ram #(
   parameter int DEPTH  = 2048,
   parameter int WIDTH  = 256,
   parameter int NREAD  = 2,
   localparam int AW    = $clog2(DEPTH)
) (
   input  logic             clk,
   input  logic             we,
   input  logic [AW-1:0]    waddr,
   input  logic [WIDTH-1:0] wdata,
   input  logic [AW-1:0]    raddr [NREAD],
   output logic [WIDTH-1:0] rdata [NREAD]
);
   logic [WIDTH-1:0] store [DEPTH];

   always_ff @(posedge clk) begin
      if (we) store[waddr] <= wdata;
   end

   // one synchronous read port per register set; old data on collision
   for (genvar p = 0; p < NREAD; p++) begin : g_rd
      always_ff @(posedge clk) begin
         rdata[p] <= store[raddr[p]];
      end
   end
endmodule

// File: rtl/trl_wr_ctrl.sv
module trl_wr_ctrl #(
   parameter int DEPTH = 2048,
   parameter int NSET  = 2,
   localparam int AW   = $clog2(DEPTH)
) (
   input  logic            clk,
   input  logic            rst,
   input  logic [NSET-1:0] freeze_vec,
   output logic            wr_en,
   output logic [AW-1:0]   wr_ptr
);
   assign wr_en = ~|freeze_vec;

   always_ff @(posedge clk) begin
      if (rst)        wr_ptr <= '0;
      else if (wr_en) wr_ptr <= wr_ptr + 1'b1;
   end
endmodule

// File: rtl/trl_side.sv
module trl_side
   import trl_pkg::*;
#(
   parameter int DEPTH   = 2048,
   parameter int TRACE_W = 256,
   localparam int AW     = $clog2(DEPTH),
   localparam int NDW    = TRACE_W / TRL_REG_W,
   localparam int SUBW   = $clog2(NDW),
   localparam int RPW    = AW + SUBW
) (
   input  logic                 clk,
   input  logic                 rst,
   input  logic                 cmd_valid,
   input  logic                 cmd_data_sel,
   input  logic                 cmd_write,
   input  logic [TRL_REG_W-1:0] cmd_wdata,
   input  logic [AW-1:0]        wr_ptr,
   input  logic [TRACE_W-1:0]   ram_rdata,
   output logic [AW-1:0]        ram_raddr,
   output logic [RPW-1:0]       rd_ptr,
   output logic                 freeze,
   output logic                 rsp_valid,
   output logic [TRL_REG_W-1:0] rsp_data
);
   logic                 is_read, is_ptr_wr, is_data_rd;
   logic                 kind_q;
   logic [SUBW-1:0]      sub_q;
   logic [TRL_REG_W-1:0] ptr_word, ptr_q;
   logic [TRL_REG_W-1:0] dw_slice [NDW];
   logic                 wdata_unused;

   assign is_read    = cmd_valid && !cmd_write;
   assign is_ptr_wr  = cmd_valid && cmd_write && (cmd_data_sel == TRL_SEL_PTR);
   assign is_data_rd = is_read && (cmd_data_sel == TRL_SEL_DATA);
   assign ram_raddr  = rd_ptr[RPW-1:SUBW];
   assign wdata_unused = ^cmd_wdata;

   always_comb begin
      ptr_word = '0;
      ptr_word[TRL_HALF_W +: AW] = wr_ptr;
      ptr_word[TRL_HALF_W + AW]  = 1'b1;       // length marker
      ptr_word[TRL_FREEZE_BIT]   = freeze;
      ptr_word[RPW-1:0]          = rd_ptr;
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         rd_ptr    <= '0;
         freeze    <= 1'b0;
         rsp_valid <= 1'b0;
         kind_q    <= 1'b0;
         sub_q     <= '0;
         ptr_q     <= '0;
      end else begin
         rsp_valid <= is_read;
         kind_q    <= cmd_data_sel;
         sub_q     <= rd_ptr[SUBW-1:0];
         ptr_q     <= ptr_word;
         if (is_ptr_wr) begin
            rd_ptr <= cmd_wdata[RPW-1:0];
            freeze <= cmd_wdata[TRL_FREEZE_BIT];
         end else if (is_data_rd) begin
            rd_ptr <= rd_ptr + 1'b1;
         end
      end
   end

   for (genvar k = 0; k < NDW; k++) begin : g_dw
      assign dw_slice[k] = ram_rdata[k*TRL_REG_W +: TRL_REG_W];
   end

   assign rsp_data = (kind_q == TRL_SEL_DATA) ? dw_slice[sub_q] : ptr_q;
endmodule

// File: rtl/trace_ring_log.sv
module trace_ring_log
   import trl_pkg::*;
#(
   parameter int DEPTH   = 2048,
   parameter int TRACE_W = 256,
   localparam int AW     = $clog2(DEPTH),
   localparam int NDW    = TRACE_W / TRL_REG_W,
   localparam int RPW    = AW + $clog2(NDW),
   localparam int NSET   = 2
) (
   input  logic                 clk,
   input  logic                 rst,
   input  logic [TRACE_W-1:0]   trace_in,
   input  logic                 cpu_cmd_valid,
   input  logic                 cpu_cmd_data_sel,
   input  logic                 cpu_cmd_write,
   input  logic [TRL_REG_W-1:0] cpu_cmd_wdata,
   output logic                 cpu_rsp_valid,
   output logic [TRL_REG_W-1:0] cpu_rsp_data,
   input  logic                 dbg_cmd_valid,
   input  logic                 dbg_cmd_data_sel,
   input  logic                 dbg_cmd_write,
   input  logic [TRL_REG_W-1:0] dbg_cmd_wdata,
   output logic                 dbg_rsp_valid,
   output logic [TRL_REG_W-1:0] dbg_rsp_data
);
   // elaboration-time parameter checks
   if (DEPTH < 2 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
      $error("trace_ring_log: DEPTH must be a power of two");
   end
   if (NDW < 2 || (NDW & (NDW - 1)) != 0 || NDW * TRL_REG_W != TRACE_W) begin : g_bad_width
      $error("trace_ring_log: TRACE_W must be a power-of-two multiple of 64");
   end
   if (RPW > TRL_FREEZE_BIT || AW + 1 > TRL_HALF_W) begin : g_bad_fit
      $error("trace_ring_log: pointers do not fit the register halves");
   end

   logic                 c_valid [NSET];
   logic                 c_sel   [NSET];
   logic                 c_write [NSET];
   logic [TRL_REG_W-1:0] c_wdata [NSET];
   logic                 r_valid [NSET];
   logic [TRL_REG_W-1:0] r_data  [NSET];
   logic [AW-1:0]        raddr   [NSET];
   logic [TRACE_W-1:0]   rdata   [NSET];
   logic [RPW-1:0]       rptr    [NSET];
   logic [NSET-1:0]      frz_vec;
   logic                 wr_en;
   logic [AW-1:0]        wr_ptr;

   // names used by the bound checker
   logic [RPW-1:0]       rp_cpu, rp_dbg;
   logic                 frz_cpu, frz_dbg;

   assign c_valid[0] = cpu_cmd_valid;  assign c_valid[1] = dbg_cmd_valid;
   assign c_sel[0]   = cpu_cmd_data_sel; assign c_sel[1] = dbg_cmd_data_sel;
   assign c_write[0] = cpu_cmd_write;  assign c_write[1] = dbg_cmd_write;
   assign c_wdata[0] = cpu_cmd_wdata;  assign c_wdata[1] = dbg_cmd_wdata;
   assign cpu_rsp_valid = r_valid[0];  assign dbg_rsp_valid = r_valid[1];
   assign cpu_rsp_data  = r_data[0];   assign dbg_rsp_data  = r_data[1];
   assign rp_cpu  = rptr[0];    assign rp_dbg  = rptr[1];
   assign frz_cpu = frz_vec[0]; assign frz_dbg = frz_vec[1];

   trl_wr_ctrl #(.DEPTH(DEPTH), .NSET(NSET)) u_wr (
      .clk(clk), .rst(rst), .freeze_vec(frz_vec),
      .wr_en(wr_en), .wr_ptr(wr_ptr)
   );

   trl_ram #(.DEPTH(DEPTH), .WIDTH(TRACE_W), .NREAD(NSET)) u_ram (
      .clk(clk), .we(wr_en), .waddr(wr_ptr), .wdata(trace_in),
      .raddr(raddr), .rdata(rdata)
   );

   for (genvar s = 0; s < NSET; s++) begin : g_set
      trl_side #(.DEPTH(DEPTH), .TRACE_W(TRACE_W)) u_side (
         .clk(clk), .rst(rst),
         .cmd_valid(c_valid[s]), .cmd_data_sel(c_sel[s]),
         .cmd_write(c_write[s]), .cmd_wdata(c_wdata[s]),
         .wr_ptr(wr_ptr), .ram_rdata(rdata[s]), .ram_raddr(raddr[s]),
         .rd_ptr(rptr[s]), .freeze(frz_vec[s]),
         .rsp_valid(r_valid[s]), .rsp_data(r_data[s])
      );
   end
endmodule

// File: rtl/trl_chk.sv
module trl_chk #(
   parameter int AW  = 11,
   parameter int RPW = 13
) (
   input logic           clk,
   input logic           rst,
   input logic           cmd_valid,
   input logic           cmd_data_sel,
   input logic           cmd_write,
   input logic [63:0]    cmd_wdata,
   input logic           rsp_valid,
   input logic [RPW-1:0] rp,
   input logic           frz,
   input logic           frz_other,
   input logic [AW-1:0]  wr_ptr
);
   logic wdata_unused;
   assign wdata_unused = ^cmd_wdata;

   assert_wp_step_R1: assert property (@(posedge clk) disable iff (rst)
      !(frz || frz_other) |=> wr_ptr == AW'($past(wr_ptr) + 1'b1));

   assert_wp_hold_R6: assert property (@(posedge clk) disable iff (rst)
      (frz || frz_other) |=> $stable(wr_ptr));

   assert_rp_step_R4: assert property (@(posedge clk) disable iff (rst)
      (cmd_valid && !cmd_write && cmd_data_sel) |=> rp == RPW'($past(rp) + 1'b1));

   assert_ptr_load_R5: assert property (@(posedge clk) disable iff (rst)
      (cmd_valid && cmd_write && !cmd_data_sel)
      |=> (rp == $past(cmd_wdata[RPW-1:0])) && (frz == $past(cmd_wdata[31])));

   assert_data_wr_ignored_R8: assert property (@(posedge clk) disable iff (rst)
      (cmd_valid && cmd_write && cmd_data_sel) |=> $stable(rp) && $stable(frz) && !rsp_valid);

   assert_rsp_on_read_R9: assert property (@(posedge clk) disable iff (rst)
      (cmd_valid && !cmd_write) |=> rsp_valid);

   assert_no_rsp_idle_R9: assert property (@(posedge clk) disable iff (rst)
      !(cmd_valid && !cmd_write) |=> !rsp_valid);

   assert_idle_keeps_rp_R7: assert property (@(posedge clk) disable iff (rst)
      !cmd_valid |=> $stable(rp) && $stable(frz));
endmodule

bind trace_ring_log trl_chk #(.AW(AW), .RPW(RPW)) u_chk_cpu (
   .clk(clk), .rst(rst), .cmd_valid(cpu_cmd_valid), .cmd_data_sel(cpu_cmd_data_sel),
   .cmd_write(cpu_cmd_write), .cmd_wdata(cpu_cmd_wdata), .rsp_valid(cpu_rsp_valid),
   .rp(rp_cpu), .frz(frz_cpu), .frz_other(frz_dbg), .wr_ptr(wr_ptr)
);

bind trace_ring_log trl_chk #(.AW(AW), .RPW(RPW)) u_chk_dbg (
   .clk(clk), .rst(rst), .cmd_valid(dbg_cmd_valid), .cmd_data_sel(dbg_cmd_data_sel),
   .cmd_write(dbg_cmd_write), .cmd_wdata(dbg_cmd_wdata), .rsp_valid(dbg_rsp_valid),
   .rp(rp_dbg), .frz(frz_dbg), .frz_other(frz_cpu), .wr_ptr(wr_ptr)
);

// File: tb/trace_ring_log_tb.sv
`timescale 1ns/1ps
module trace_ring_log_tb;
   localparam int D   = 16;
   localparam int TW  = 256;
   localparam int RPW = $clog2(D) + 2;

   logic          clk = 1'b0;
   logic          rst = 1'b1;
   logic [TW-1:0] trace_in = '0;
   logic          b_valid [2];
   logic          b_sel   [2];
   logic          b_wr    [2];
   logic [63:0]   b_wd    [2];
   logic          cpu_rsp_valid, dbg_rsp_valid;
   logic [63:0]   cpu_rsp_data, dbg_rsp_data;

   int    n_tests = 0;
   int    n_fail  = 0;
   int    cyc     = 0;
   string cur_tag = "R9";

   // reference model state
   logic [TW-1:0] m_mem [D];
   int            m_wp;
   int            m_rp  [2];
   bit            m_frz [2];
   bit            e_valid [2];
   bit            e_kind  [2];
   logic [63:0]   e_data  [2];

   always #4 clk = ~clk;

   trace_ring_log #(.DEPTH(D), .TRACE_W(TW)) u_dut (
      .clk(clk), .rst(rst), .trace_in(trace_in),
      .cpu_cmd_valid(b_valid[0]), .cpu_cmd_data_sel(b_sel[0]),
      .cpu_cmd_write(b_wr[0]), .cpu_cmd_wdata(b_wd[0]),
      .cpu_rsp_valid(cpu_rsp_valid), .cpu_rsp_data(cpu_rsp_data),
      .dbg_cmd_valid(b_valid[1]), .dbg_cmd_data_sel(b_sel[1]),
      .dbg_cmd_write(b_wr[1]), .dbg_cmd_wdata(b_wd[1]),
      .dbg_rsp_valid(dbg_rsp_valid), .dbg_rsp_data(dbg_rsp_data)
   );

   function automatic logic [TW-1:0] make_trace(input int c);
      logic [TW-1:0] t;
      for (int k = 0; k < 4; k++) t[k*64 +: 64] = {8'(k), 24'h5a3c96, 32'(c)};
      return t;
   endfunction

   function automatic logic [63:0] ptr_word(input int wp, input bit f, input int rp);
      return {32'(wp) | 32'(D), f, 31'(rp)};
   endfunction

   // behavioural model, advanced on every clock
   always @(posedge clk) begin
      if (rst) begin
         m_wp = 0;
         for (int s = 0; s < 2; s++) begin
            m_rp[s] = 0; m_frz[s] = 0; e_valid[s] = 0; e_kind[s] = 0; e_data[s] = '0;
         end
      end else begin
         bit frozen;
         frozen = m_frz[0] | m_frz[1];
         for (int s = 0; s < 2; s++) begin
            e_valid[s] = b_valid[s] && !b_wr[s];
            if (e_valid[s]) begin
               e_kind[s] = b_sel[s];
               if (!b_sel[s]) e_data[s] = ptr_word(m_wp, m_frz[s], m_rp[s]);
               else           e_data[s] = m_mem[m_rp[s] / 4][(m_rp[s] % 4) * 64 +: 64];
            end
         end
         for (int s = 0; s < 2; s++) begin
            if (b_valid[s] && b_wr[s] && !b_sel[s]) begin
               m_rp[s]  = int'(b_wd[s][RPW-1:0]);
               m_frz[s] = b_wd[s][31];
            end else if (b_valid[s] && !b_wr[s] && b_sel[s]) begin
               m_rp[s] = (m_rp[s] + 1) % (4 * D);
            end
         end
         if (!frozen) begin
            m_mem[m_wp] = trace_in;
            m_wp = (m_wp + 1) % D;
         end
      end
   end

   // compare on every clock, away from the active edge
   always @(negedge clk) begin
      if (!rst) begin
         for (int s = 0; s < 2; s++) begin
            logic        av;
            logic [63:0] ad;
            av = (s == 0) ? cpu_rsp_valid : dbg_rsp_valid;
            ad = (s == 0) ? cpu_rsp_data  : dbg_rsp_data;
            if (av || e_valid[s]) begin
               n_tests++;
               if (av !== e_valid[s]) begin
                  n_fail++;
                  $display("FAIL R9 [%s] side %0d rsp_valid actual=%0b expected=%0b", cur_tag, s, av, e_valid[s]);
               end else if (ad !== e_data[s]) begin
                  n_fail++;
                  $display("FAIL %s [%s] side %0d rsp_data actual=%h expected=%h",
                           e_kind[s] ? "R3" : "R2", cur_tag, s, ad, e_data[s]);
               end
            end
         end
      end
   end

   always @(negedge clk) begin
      cyc <= cyc + 1;
      trace_in <= make_trace(cyc + 1);
   end

   task automatic issue(input int s, input bit sel, input bit wr, input logic [63:0] wd, input int n);
      @(negedge clk);
      b_valid[s] = 1'b1; b_sel[s] = sel; b_wr[s] = wr; b_wd[s] = wd;
      repeat (n) @(negedge clk);
      b_valid[s] = 1'b0; b_sel[s] = 1'b0; b_wr[s] = 1'b0; b_wd[s] = '0;
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic scenario();
      int w;
      // R9: reset state and no stray response
      idle(1);
      n_tests++;
      if (cpu_rsp_valid !== 1'b0 || dbg_rsp_valid !== 1'b0) begin
         n_fail++;
         $display("FAIL R9 reset rsp_valid actual=%0b%0b expected=00", cpu_rsp_valid, dbg_rsp_valid);
      end
      cur_tag = "R9"; issue(0, 0, 0, '0, 1);   // pointer read just after reset
      cur_tag = "R1"; idle(20);                  // write pointer runs past the wrap
      issue(0, 0, 0, '0, 1);
      issue(1, 0, 0, '0, 1);
      // R5: load read pointer 5 and freeze, with junk in ignored bits
      cur_tag = "R5"; issue(0, 0, 1, 64'hFFFF_0000_8000_0005, 1);
      issue(0, 0, 0, '0, 1);
      // R6: write pointer holds while frozen
      cur_tag = "R6"; idle(5); issue(0, 0, 0, '0, 1);
      // R3/R4: back-to-back data reads across entry boundaries
      cur_tag = "R3"; issue(0, 1, 0, '0, 8);
      cur_tag = "R4"; issue(0, 0, 0, '0, 1);
      issue(0, 0, 1, 64'h0000_0000_8000_0000 | 64'(4*D-2), 1);
      issue(0, 1, 0, '0, 3);                     // wraps to 0
      issue(0, 0, 0, '0, 1);
      // R7: debug set untouched by processor traffic
      cur_tag = "R7"; issue(1, 0, 0, '0, 1);
      issue(1, 1, 0, '0, 5);
      issue(0, 0, 0, '0, 1);
      // R8: data register write has no effect
      cur_tag = "R8"; issue(0, 1, 1, 64'hDEAD_BEEF_8000_0001, 1);
      issue(0, 0, 0, '0, 1);
      // R6: freeze from debug, release processor, then release debug
      cur_tag = "R6"; issue(1, 0, 1, 64'h8000_0002, 1);
      issue(0, 0, 1, 64'h0000_0004, 1);
      idle(3); issue(1, 0, 0, '0, 1);
      issue(1, 0, 1, 64'h0000_0002, 1);
      idle(3); issue(1, 0, 0, '0, 1);
      // R10: data read aimed at the slot written in the same cycle
      cur_tag = "R10";
      @(negedge clk);
      w = m_wp;
      b_valid[0] = 1'b1; b_sel[0] = 1'b0; b_wr[0] = 1'b1; b_wd[0] = 64'(4 * ((w + 2) % D));
      @(negedge clk);
      b_valid[0] = 1'b0; b_wr[0] = 1'b0; b_wd[0] = '0;
      @(negedge clk);
      b_valid[0] = 1'b1; b_sel[0] = 1'b1;
      @(negedge clk);
      b_valid[0] = 1'b0; b_sel[0] = 1'b0;
      // running reads while unfrozen on both sides
      cur_tag = "R1"; issue(0, 1, 0, '0, 6);
      issue(1, 0, 0, '0, 1);
      idle(4);
   endtask

   initial begin
      for (int s = 0; s < 2; s++) begin
         b_valid[s] = 1'b0; b_sel[s] = 1'b0; b_wr[s] = 1'b0; b_wd[s] = '0;
      end
      repeat (3) @(negedge clk);
      rst = 1'b0;
      fork
         scenario();
         begin
            repeat (20000) @(posedge clk);
            n_fail++;
            $display("FAIL watchdog expired actual=running expected=done");
         end
      join_any
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end
endmodule